// File: doc/BRIEF.md
# Dual-Address DMA Channel Engine

This block is one DMA channel that copies data between two places on a 32-bit memory bus. Each transfer unit takes two bus cycles. The first reads the unit from the source address. The second writes it to the destination address. Software sets up the channel through a small register file: a source address, a destination address, a byte count, a control word and a status word. It then sets the go bit in the control word.

A unit is a byte, a halfword or a full 32-bit word. Each side of the transfer can step its address by the unit size after every unit, or keep it fixed, as a device register needs. Every bus access is a full 32-bit word access. The channel extracts the unit from the byte lanes that the source address selects. It then places the unit on the lanes that the destination address selects, and raises only those byte enables.

The channel can run freely, or it can be paced by an external request line. Pacing has two forms. A single request can release the whole transfer, or, in cycle-steal form, each request moves exactly one unit. When the byte count reaches zero the channel sets DONE and can raise an interrupt. Writing 1 to DONE clears the status and cancels a transfer that is still in progress.

Top module: `dma_dual_chan`

## Requirements
- R1: Every unit is one bus read at the source address followed directly by one bus write at the destination address. A transfer of C bytes with unit size S makes exactly C/S reads and C/S writes.
- R2: The control fields for unit size map code 1 to a byte, code 2 to a halfword, and codes 0 and 3 to a 32-bit word. The read unit is taken from lane offset src[1:0]. It is written at lane offset dst[1:0], and the byte enables are the S-bit mask shifted left by that offset. Bus addresses are word-aligned. Lane k carries bits [8k+7:8k] and holds byte address 4*word+k.
- R3: Control bit 6 (source) and bit 10 (destination) select stepping. When the bit is 1, that address advances by S after each unit. When it is 0, every unit uses the same address.
- R4: The count register at offset 2 holds bytes, keeps only its low 24 bits, drops by S after each written unit, and reads 0 when the transfer ends.
- R5: Control bit 2 enables the request line and bit 3 selects cycle steal. With cycle steal set, each rising edge of ext_req moves exactly one unit. With only bit 2 set, one rising edge releases the whole transfer. While bit 2 is 0, edges are ignored. Bit 2 may be changed while the channel is busy.
- R6: A start is refused when any of these holds: the count is zero, the count or either address is not a multiple of S, or the two size codes map to different sizes. A refused start sets status bit 2 (config error) and issues no bus cycle.
- R7: At the end of a transfer, status bit 0 (DONE) is set. irq equals DONE AND control bit 1, so it stays high until DONE is cleared.
- R8: Writing 1 to status bit 0 clears DONE and the config error. It also cancels an active transfer: a bus cycle already in progress completes, and after that no further bus cycle occurs and the count is no longer changed.
- R9: Status bit 1 (BUSY) is 1 from an accepted start until the last write completes or a cancel takes effect.
- R10: While bus_valid is high and bus_ready is low, bus_addr, bus_be, bus_write and bus_wdata hold their values into the next cycle.
- R11: After reset every register reads 0, and irq and bus_valid are low. The register offsets are 0 source, 1 destination, 2 count, 3 control (bit 0 is go and reads as 0) and 4 status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | output | 1 | Bus cycle request |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Bus cycle completes this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| ext_req | input | 1 | External transfer request |
| irq | output | 1 | Completion interrupt |

## Verification
Five properties are checked on every cycle:
- the bus holds its address, enables and data until ready;
- a write cycle is always preceded by a completed read;
- the number of enabled lanes always equals the unit size;
- the count never rises during a transfer and is zero when DONE appears;
- a config error never coexists with BUSY, and a cycle-steal unit always ends with the bus released.

Some behaviours can only be shown by the bench scenarios, which compare memory contents against a byte-level copy model:
- the correct lane steering for every size, offset and stepping combination;
- that the pacing edges map to the right number of units;
- that cancels and disabled requests really leave the count and the bus untouched.

// File: rtl/dma_dual_chan.sv
module dma_dual_chan #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [3:0]    bus_be,
  output logic [31:0]   bus_wdata,
  input  logic          bus_ready,
  input  logic [31:0]   bus_rdata,
  input  logic          ext_req,
  output logic          irq
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RD, S_WR} st_t;

  function automatic logic [2:0] code_bytes(input logic [1:0] c);
    case (c)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [2:0] n);
    case (n)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  st_t            st;
  logic [AW-1:0]  src_q, dst_q;
  logic [CW-1:0]  cnt_q;
  logic           irq_en, req_en, steal, s_inc, d_inc;
  logic [1:0]     s_code, d_code;
  logic           done_q, err_q, abort_q, req_q;
  logic [31:0]    data_q;

  wire busy     = (st != S_IDLE);
  wire wr_src   = reg_wr && (reg_addr == 3'd0);
  wire wr_dst   = reg_wr && (reg_addr == 3'd1);
  wire wr_cnt   = reg_wr && (reg_addr == 3'd2);
  wire wr_ctrl  = reg_wr && (reg_addr == 3'd3);
  wire wr_stat  = reg_wr && (reg_addr == 3'd4);
  wire kick     = wr_ctrl && reg_wdata[0] && !busy;
  wire clr      = wr_stat && reg_wdata[0];
  wire stop     = clr || abort_q;
  wire req_edge = ext_req && !req_q;

  wire [2:0] ubytes = code_bytes(s_code);
  wire [CW-1:0] ub_c = CW'(ubytes);
  wire [AW-1:0] ub_a = AW'(ubytes);
  wire last = (cnt_q == ub_c);

  wire [2:0] nb_s = code_bytes(reg_wdata[5:4]);
  wire [2:0] nb_d = code_bytes(reg_wdata[9:8]);
  wire [1:0] nm   = 2'(nb_s - 3'd1);
  wire bad = (nb_s != nb_d) || (cnt_q == '0) ||
             |(cnt_q[1:0] & nm) || |(src_q[1:0] & nm) || |(dst_q[1:0] & nm);

  wire [4:0] rd_sh = {src_q[1:0], 3'b000};
  wire [4:0] wr_sh = {dst_q[1:0], 3'b000};
  wire [AW-1:0] cur_addr = (st == S_WR) ? dst_q : src_q;

  assign bus_valid = (st == S_RD) || (st == S_WR);
  assign bus_write = (st == S_WR);
  assign bus_addr  = {cur_addr[AW-1:2], 2'b00};
  assign bus_be    = bus_valid ? (lane_mask(ubytes) << cur_addr[1:0]) : 4'b0000;
  assign bus_wdata = data_q << wr_sh;
  assign irq       = done_q && irq_en;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'(src_q);
      3'd1:    reg_rdata = 32'(dst_q);
      3'd2:    reg_rdata = 32'(cnt_q);
      3'd3:    reg_rdata = {21'b0, d_inc, d_code, 1'b0, s_inc, s_code, steal, req_en, irq_en, 1'b0};
      3'd4:    reg_rdata = {29'b0, err_q, busy, done_q};
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      irq_en  <= 1'b0;
      req_en  <= 1'b0;
      steal   <= 1'b0;
      s_inc   <= 1'b0;
      d_inc   <= 1'b0;
      s_code  <= 2'd0;
      d_code  <= 2'd0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
      req_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      req_q <= ext_req;
      if (!busy) begin
        if (wr_src) src_q <= reg_wdata[AW-1:0];
        if (wr_dst) dst_q <= reg_wdata[AW-1:0];
        if (wr_cnt) cnt_q <= reg_wdata[CW-1:0];
      end
      if (wr_ctrl) begin
        irq_en <= reg_wdata[1];
        req_en <= reg_wdata[2];
        if (!busy) begin
          steal  <= reg_wdata[3];
          s_code <= reg_wdata[5:4];
          s_inc  <= reg_wdata[6];
          d_code <= reg_wdata[9:8];
          d_inc  <= reg_wdata[10];
        end
      end
      if (clr) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (kick) begin
        done_q <= 1'b0;
        err_q  <= bad;
      end
      case (st)
        S_IDLE: begin
          if (kick && !bad) st <= (reg_wdata[2] || reg_wdata[3]) ? S_WAIT : S_RD;
        end
        S_WAIT: begin
          if (clr) st <= S_IDLE;
          else if (req_en && req_edge) st <= S_RD;
        end
        S_RD: begin
          if (bus_ready) begin
            data_q <= bus_rdata >> rd_sh;
            if (stop) begin
              st      <= S_IDLE;
              abort_q <= 1'b0;
            end else begin
              st <= S_WR;
            end
          end else if (clr) begin
            abort_q <= 1'b1;
          end
        end
        S_WR: begin
          if (bus_ready) begin
            cnt_q <= cnt_q - ub_c;
            if (s_inc) src_q <= src_q + ub_a;
            if (d_inc) dst_q <= dst_q + ub_a;
            if (last) begin
              done_q  <= 1'b1;
              st      <= S_IDLE;
              abort_q <= 1'b0;
            end else if (stop) begin
              st      <= S_IDLE;
              abort_q <= 1'b0;
            end else begin
              st <= steal ? S_WAIT : S_RD;
            end
          end else if (clr) begin
            abort_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_be)
                               && $stable(bus_write) && $stable(bus_wdata)); // R10
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) && !$past(bus_valid && bus_write)
      |-> $past(bus_valid && !bus_write && bus_ready)); // R1
  AST_LANE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ($countones(bus_be) == 32'(ubytes))); // R2
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> (cnt_q <= $past(cnt_q))); // R4
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (cnt_q == '0)); // R4
  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !busy); // R6
  AST_STEAL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    steal && bus_valid && bus_write && bus_ready |=> !bus_valid); // R5

endmodule

// File: tb/dma_dual_chan_tb.sv
`timescale 1ns/1ps
module dma_dual_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        bus_valid, bus_write;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_rdata = 32'd0;
  logic        ext_req = 1'b0;
  logic        irq;

  always #5 clk = ~clk;

  dma_dual_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .ext_req(ext_req), .irq(irq)
  );

  logic [7:0] mem  [0:255];
  logic [7:0] refm [0:255];
  int n_cmp = 0, n_err = 0;
  int nrd = 0, nwr = 0, ord_err = 0, hold_err = 0;
  int wcnt = 0, dly = 0;
  logic last_rd = 1'b0;
  logic pend = 1'b0;
  logic [31:0] h_addr, h_wdata;
  logic [3:0]  h_be;
  logic        h_wr;

  always @(posedge clk) begin
    if (pend) begin
      if (!bus_valid || bus_addr !== h_addr || bus_be !== h_be ||
          bus_write !== h_wr || bus_wdata !== h_wdata) hold_err++;
    end
    pend    = bus_valid && !bus_ready;
    h_addr  = bus_addr;
    h_be    = bus_be;
    h_wr    = bus_write;
    h_wdata = bus_wdata;
    if (bus_valid && bus_ready) begin
      if (bus_write) begin
        nwr++;
        if (!last_rd) ord_err++;
        last_rd = 1'b0;
        for (int k = 0; k < 4; k++)
          if (bus_be[k]) mem[{bus_addr[7:2], 2'(k)}] = bus_wdata[8*k +: 8];
      end else begin
        nrd++;
        if (last_rd) ord_err++;
        last_rd = 1'b1;
      end
    end
    if (bus_valid && !bus_ready) begin
      if (wcnt >= dly) begin
        bus_ready <= 1'b1;
        bus_rdata <= {mem[{bus_addr[7:2], 2'd3}], mem[{bus_addr[7:2], 2'd2}],
                      mem[{bus_addr[7:2], 2'd1}], mem[{bus_addr[7:2], 2'd0}]};
        wcnt = 0;
        dly  = (dly + 1) % 3;
      end else begin
        wcnt++;
      end
    end else begin
      bus_ready <= 1'b0;
    end
  end

  task automatic finish_sim();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog: act=hung exp=finished");
    finish_sim();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl(input logic go, input logic ie, input logic re,
      input logic st, input logic [1:0] sc, input logic si, input logic [1:0] dc, input logic di);
    return {21'b0, di, dc, 1'b0, si, sc, st, re, ie, go};
  endfunction

  function automatic int sz_of(input logic [1:0] c);
    return (c == 2'd1) ? 1 : (c == 2'd2) ? 2 : 4;
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'(i * 7 + 3);
      refm[i] = 8'(i * 7 + 3);
    end
    nrd = 0; nwr = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd4, s);
      if (!s[1]) break;
    end
  endtask

  task automatic pulse();
    @(negedge clk); ext_req = 1'b1;
    @(negedge clk); ext_req = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic sweep(input logic [1:0] sc, input logic [1:0] dc, input logic si,
                       input logic di, input int so, input int dof, input int nu);
    int sz, bad;
    logic [31:0] v;
    sz = sz_of(sc);
    init_mem();
    for (int u = 0; u < nu; u++) begin
      int s, d;
      s = so + (si ? u * sz : 0);
      d = dof + (di ? u * sz : 0);
      for (int b = 0; b < sz; b++) refm[d + b] = refm[s + b];
    end
    wr(3'd0, 32'(so));
    wr(3'd1, 32'(dof));
    wr(3'd2, 32'(nu * sz));
    wr(3'd3, ctl(1'b1, 1'b1, 1'b0, 1'b0, sc, si, dc, di));
    rd(3'd4, v);
    chk("R9 busy after start", 32'(v[1]), 32'd1);
    wait_idle();
    rd(3'd2, v);
    chk("R4 count zero at end", v, 32'd0);
    rd(3'd4, v);
    chk("R7 done status", v, 32'h1);
    chk("R7 irq raised", 32'(irq), 32'd1);
    chk("R1 read count", 32'(nrd), 32'(nu));
    chk("R1 write count", 32'(nwr), 32'(nu));
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) bad++;
    chk("R2 R3 memory image", 32'(bad), 32'd0);
    wr(3'd4, 32'h1);
    chk("R7 irq cleared", 32'(irq), 32'd0);
  endtask

  initial begin
    logic [31:0] v, c0;
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R11 reset register", v, 32'd0);
    end
    chk("R11 reset irq", 32'(irq), 32'd0);
    chk("R11 reset bus_valid", 32'(bus_valid), 32'd0);

    wr(3'd2, 32'hFFAB_CDEF);
    rd(3'd2, v);
    chk("R4 count keeps 24 bits", v, 32'h00AB_CDEF);

    for (int ic = 0; ic < 3; ic++) begin
      logic si, di;
      si = (ic != 2);
      di = (ic != 1);
      sweep(2'd1, 2'd1, si, di, 1, 131, 7);
      sweep(2'd2, 2'd2, si, di, 2, 128, 5);
      sweep(2'd0, 2'd0, si, di, 4, 136, 6);
      sweep(2'd3, 2'd0, si, di, 8, 160, 3);
      sweep(2'd1, 2'd1, si, di, 2, 128, 4);
      sweep(2'd2, 2'd2, si, di, 0, 142, 3);
    end

    init_mem();
    wr(3'd0, 32'd4); wr(3'd1, 32'd128); wr(3'd2, 32'd6);
    wr(3'd3, ctl(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1));
    repeat (5) @(negedge clk);
    rd(3'd4, v);
    chk("R6 count misaligned", v, 32'h4);
    chk("R6 no bus cycle", 32'(nrd), 32'd0);
    wr(3'd4, 32'h1);
    rd(3'd4, v);
    chk("R8 clear config error", v, 32'h0);

    wr(3'd0, 32'd1); wr(3'd2, 32'd8);
    wr(3'd3, ctl(1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 2'd2, 1'b1));
    rd(3'd4, v);
    chk("R6 address misaligned", v, 32'h4);
    wr(3'd0, 32'd0);
    wr(3'd3, ctl(1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 2'd2, 1'b1));
    rd(3'd4, v);
    chk("R6 size mismatch", v, 32'h4);
    wr(3'd2, 32'd0);
    wr(3'd3, ctl(1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 2'd1, 1'b1));
    rd(3'd4, v);
    chk("R6 zero count", v, 32'h4);
    chk("R6 no bus cycle after refusals", 32'(nrd), 32'd0);
    wr(3'd4, 32'h1);

    wr(3'd2, 32'd8);
    wr(3'd3, ctl(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1));
    wait_idle();
    rd(3'd4, v);
    chk("R7 done with irq disabled", v, 32'h1);
    chk("R7 irq masked", 32'(irq), 32'd0);
    wr(3'd4, 32'h1);

    init_mem();
    wr(3'd0, 32'd0); wr(3'd1, 32'd128); wr(3'd2, 32'd8);
    wr(3'd3, ctl(1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 2'd2, 1'b1));
    repeat (10) @(negedge clk);
    rd(3'd2, v);
    chk("R5 waits for request", v, 32'd8);
    chk("R5 no bus before request", 32'(nrd), 32'd0);
    pulse();
    rd(3'd2, v);
    chk("R5 one unit per request", v, 32'd6);
    pulse();
    rd(3'd2, v);
    chk("R5 second request one unit", v, 32'd4);
    wr(3'd3, ctl(1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 2'd2, 1'b1));
    pulse();
    rd(3'd2, v);
    chk("R5 request ignored while disabled", v, 32'd4);
    wr(3'd3, ctl(1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 2'd2, 1'b1));
    pulse();
    pulse();
    rd(3'd2, v);
    chk("R5 steal finishes", v, 32'd0);
    rd(3'd4, v);
    chk("R5 steal done", v, 32'h1);
    chk("R1 steal unit count", 32'(nwr), 32'd4);
    wr(3'd4, 32'h1);

    init_mem();
    wr(3'd0, 32'd0); wr(3'd1, 32'd128); wr(3'd2, 32'd12);
    wr(3'd3, ctl(1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1));
    repeat (8) @(negedge clk);
    chk("R5 start waits for request", 32'(nrd), 32'd0);
    @(negedge clk); ext_req = 1'b1;
    @(negedge clk); ext_req = 1'b0;
    wait_idle();
    rd(3'd2, v);
    chk("R5 one request runs all", v, 32'd0);
    chk("R5 all units moved", 32'(nwr), 32'd3);
    wr(3'd4, 32'h1);

    init_mem();
    wr(3'd0, 32'd0); wr(3'd1, 32'd128); wr(3'd2, 32'd64);
    wr(3'd3, ctl(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1));
    repeat (6) @(negedge clk);
    wr(3'd4, 32'h1);
    repeat (12) @(negedge clk);
    rd(3'd4, v);
    chk("R8 abort leaves idle not done", v, 32'h0);
    rd(3'd2, c0);
    chk("R8 abort left work undone", 32'(c0 != 0 && c0 < 64), 32'd1);
    begin
      int r0;
      r0 = nrd;
      repeat (20) @(negedge clk);
      rd(3'd2, v);
      chk("R8 count frozen after abort", v, c0);
      chk("R8 no bus after abort", 32'(nrd), 32'(r0));
    end

    chk("R1 read/write alternation", 32'(ord_err), 32'd0);
    chk("R10 bus held until ready", 32'(hold_err), 32'd0);
    finish_sim();
  end
endmodule